// File: doc/BRIEF.md
# Threshold-Interrupt Bidirectional Byte FIFO

This block is a 16-byte FIFO that sits between a host using programmed I/O and a peripheral engine. A direction input picks which side fills the buffer and which side drains it. In the forward direction the host writes bytes and the peripheral pops them. In the reverse direction the peripheral pushes bytes and the host reads them. The requests of the side that is not active in the current direction are ignored.

A 4-bit threshold controls a one-cycle service interrupt, and the condition depends on the direction. In the reverse direction the interrupt fires once enough bytes have built up for the host to drain a burst. In the forward direction it fires once enough space has opened up for the host to write a burst.

When the interrupt fires, hardware sets a service-busy bit. That bit masks further interrupts until the host clears it. The host reads the full and empty flags to decide how large a burst to move. It can move the whole FIFO if the buffer is full (reverse) or empty (forward), or it can move a threshold-sized burst.

Top module: `thresh_fifo_irq`

## Requirements
- R1: After synchronous reset, `level` is 0, `empty` is 1, `full` is 0, `irq` is 0 and `svc_busy` is 1 (interrupts masked).
- R2: Bytes leave in the order they were accepted. `rd_data` shows the popped byte from the cycle after an accepted read and holds that value until the next accepted read.
- R3: With `dir_rev`=0 (forward), `host_wr` writes and `per_pop` reads, and `per_push` and `host_rd` are ignored. With `dir_rev`=1 (reverse), `per_push` writes and `host_rd` reads, and `host_wr` and `per_pop` are ignored.
- R4: A write while `full` is 1 is dropped. `level` stays unchanged and the dropped byte is never read out.
- R5: A read while `empty` is 1 is ignored. `level` stays at 0 and `rd_data` holds its value.
- R6: A write and a read accepted in the same cycle leave `level` unchanged.
- R7: Forward: when `svc_busy` is 0 and `level` <= `thresh`, `irq` pulses high for one cycle on the next clock, and `svc_busy` becomes 1 on that same clock.
- R8: Reverse: when `svc_busy` is 0 and `level` >= 16 - `thresh`, `irq` pulses for one cycle on the next clock and `svc_busy` becomes 1. With `thresh`=0 it fires only when the FIFO is full.
- R9: While `svc_busy` is 1, no interrupt fires even if the condition holds. A one-cycle `svc_clr` pulse sets `svc_busy` to 0 and re-arms the interrupt.
- R10: A change of `dir_rev` empties the FIFO. `level` is 0 on the next clock, and reads and writes requested in the cycle of the change are ignored.
- R11: `full` is 1 exactly when `level` is 16 and `empty` is 1 exactly when `level` is 0. `level` never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_rev | input | 1 | 0 = host fills / peripheral drains, 1 = peripheral fills / host drains |
| host_wr | input | 1 | Host write strobe (forward only) |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe (reverse only) |
| per_push | input | 1 | Peripheral push strobe (reverse only) |
| per_wdata | input | 8 | Peripheral push byte |
| per_pop | input | 1 | Peripheral pop strobe (forward only) |
| thresh | input | 4 | Interrupt threshold |
| svc_clr | input | 1 | Clears the service-busy bit |
| rd_data | output | 8 | Last byte read out |
| level | output | 5 | Bytes held, 0 to 16 |
| full | output | 1 | FIFO holds 16 bytes |
| empty | output | 1 | FIFO holds no bytes |
| irq | output | 1 | One-cycle service interrupt |
| svc_busy | output | 1 | Service bit; 1 masks the interrupt |

## Verification
The bench builds the block with its default sizes: 16 entries of 8 bits and a 4-bit threshold. At these sizes a full fill, a full drain and both edges of the threshold range take only a few dozen cycles. This lets the bench reach the wrap of both pointers, a dropped write at full and an ignored read at empty. It also covers threshold 12 in both directions and threshold 0 in reverse, where the interrupt waits for the sixteenth byte.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef enum logic {
    XFER_FWD = 1'b0,
    XFER_REV = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          full_q,
  output logic          empty_q
);
  logic [CW-1:0] cnt_nx;

  assign wr_ok  = wr_req && !full_q  && !flush;
  assign rd_ok  = rd_req && !empty_q && !flush;
  assign cnt_nx = count + CW'(wr_ok) - CW'(rd_ok);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count   <= cnt_nx;
      full_q  <= (cnt_nx == CW'(DEPTH));
      empty_q <= (cnt_nx == '0);
    end
  end

  a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (!flush && full_q && wr_req && !rd_req) |=> (count == CW'(DEPTH)));
  a_r5_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
    (!flush && empty_q && rd_req && !wr_req) |=> (count == '0));
  a_r6_both_hold_level: assert property (@(posedge clk) disable iff (rst)
    (!flush && wr_req && rd_req && !full_q && !empty_q) |=> $stable(count));
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && empty_q));
  a_r11_level_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int DEPTH = 16,
  parameter int TW = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          dir_rev,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thresh,
  input  logic          svc_clr,
  output logic          irq,
  output logic          svc
);
  logic [CW-1:0] thr_w;
  logic          fwd_hit, rev_hit, fire;

  assign thr_w   = CW'(thresh);
  assign fwd_hit = (count <= thr_w);
  assign rev_hit = (count >= (CW'(DEPTH) - thr_w));
  assign fire    = !svc && !flush && (dir_rev ? rev_hit : fwd_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      svc <= 1'b1;
    end else begin
      irq <= fire;
      if (fire)         svc <= 1'b1;
      else if (svc_clr) svc <= 1'b0;
    end
  end

  a_r7_fwd_cause: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(dir_rev)) |-> ($past(count) <= CW'($past(thresh))));
  a_r8_rev_cause: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(dir_rev)) |-> ($past(count) >= CW'(DEPTH) - CW'($past(thresh))));
  a_r9_irq_masks: assert property (@(posedge clk) disable iff (rst)
    irq |-> svc);
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(svc) |-> !irq);
endmodule

// File: rtl/thresh_fifo_irq.sv
module thresh_fifo_irq #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  parameter int TW = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_rev,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          per_push,
  input  logic [DW-1:0] per_wdata,
  input  logic          per_pop,
  input  logic [TW-1:0] thresh,
  input  logic          svc_clr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          irq,
  output logic          svc_busy
);
  import pio_fifo_pkg::*;

  xfer_dir_e     dir_now, dir_q;
  logic          flush, wr_req, rd_req, wr_ok, rd_ok;
  logic [AW-1:0] wptr, rptr;
  logic [DW-1:0] wdata;

  assign dir_now = xfer_dir_e'(dir_rev);
  assign flush   = (dir_now != dir_q);
  assign wr_req  = (dir_now == XFER_REV) ? per_push : host_wr;
  assign rd_req  = (dir_now == XFER_REV) ? host_rd  : per_pop;
  assign wdata   = (dir_now == XFER_REV) ? per_wdata : host_wdata;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= XFER_FWD;
    else     dir_q <= dir_now;
  end

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .wr_req(wr_req), .rd_req(rd_req),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
    .count(level), .full_q(full), .empty_q(empty)
  );

  fifo_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .we(wr_ok), .waddr(wptr), .wdata(wdata),
    .re(rd_ok), .raddr(rptr), .rdata(rd_data)
  );

  irq_gen #(.DEPTH(DEPTH), .TW(TW)) u_irq (
    .clk(clk), .rst(rst), .flush(flush), .dir_rev(dir_q == XFER_REV),
    .count(level), .thresh(thresh), .svc_clr(svc_clr),
    .irq(irq), .svc(svc_busy)
  );

  a_r3_idle_side_ignored: assert property (@(posedge clk) disable iff (rst)
    (!flush && !wr_req && !rd_req) |=> $stable(level));
  a_r11_flags_match: assert property (@(posedge clk) disable iff (rst)
    (full == (level == CW'(DEPTH))) && (empty == (level == '0)));
endmodule

// File: tb/tb_thresh_fifo_irq.sv
`timescale 1ns/1ps
module tb_thresh_fifo_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_rev = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, per_push = 1'b0, per_pop = 1'b0;
  logic [7:0] host_wdata = '0, per_wdata = '0;
  logic [3:0] thresh = 4'd12;
  logic       svc_clr = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       full, empty, irq, svc_busy;
  int         n_chk = 0;
  int         n_err = 0;

  always #2.5 clk = ~clk;

  thresh_fifo_irq dut (
    .clk(clk), .rst(rst), .dir_rev(dir_rev), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .per_push(per_push),
    .per_wdata(per_wdata), .per_pop(per_pop), .thresh(thresh),
    .svc_clr(svc_clr), .rd_data(rd_data), .level(level), .full(full),
    .empty(empty), .irq(irq), .svc_busy(svc_busy)
  );

  // ops: [3] host_wr [2] host_rd [1] per_push [0] per_pop
  // vector: ops(4) data(8) exp_level(5) chk_rd(1) exp_rd(8)
  localparam logic [25:0] VEC [10] = '{
    {4'b1000, 8'h11, 5'd1, 1'b0, 8'h00},
    {4'b1000, 8'h22, 5'd2, 1'b0, 8'h00},
    {4'b1000, 8'h33, 5'd3, 1'b0, 8'h00},
    {4'b0010, 8'h99, 5'd3, 1'b0, 8'h00},
    {4'b0100, 8'h00, 5'd3, 1'b0, 8'h00},
    {4'b0001, 8'h00, 5'd2, 1'b1, 8'h11},
    {4'b1001, 8'h44, 5'd2, 1'b1, 8'h22},
    {4'b0001, 8'h00, 5'd1, 1'b1, 8'h33},
    {4'b0001, 8'h00, 5'd0, 1'b1, 8'h44},
    {4'b0001, 8'h00, 5'd0, 1'b1, 8'h44}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ops, input logic [7:0] d);
    host_wr = ops[3]; host_rd = ops[2]; per_push = ops[1]; per_pop = ops[0];
    host_wdata = d; per_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; per_push = 1'b0; per_pop = 1'b0;
  endtask

  task automatic clear_svc();
    svc_clr = 1'b1;
    @(negedge clk);
    svc_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 irq", irq, 0);
    chk("R1 svc_busy", svc_busy, 1);

    // Table walk, forward direction, interrupts masked
    for (int i = 0; i < 10; i++) begin
      step(VEC[i][25:22], VEC[i][21:14]);
      chk($sformatf("R3/R5/R6 vec%0d level", i), level, int'(VEC[i][13:9]));
      if (VEC[i][8]) chk($sformatf("R2 vec%0d rd_data", i), rd_data, int'(VEC[i][7:0]));
    end

    // R4 / R11: fill to full, overflow dropped, drain in order
    for (int i = 0; i < 16; i++) step(4'b1000, 8'(8'h60 + i));
    chk("R11 full at 16", full, 1);
    chk("R11 empty at 16", empty, 0);
    step(4'b1000, 8'hEE);
    chk("R4 level after dropped write", level, 16);
    for (int i = 0; i < 16; i++) begin
      step(4'b0001, 8'h00);
      chk("R2 drain order", rd_data, 8'h60 + i);
    end
    chk("R4 dropped byte absent, empty", empty, 1);
    chk("R11 level zero", level, 0);

    // R7 / R9 forward interrupt at threshold 12
    thresh = 4'd12;
    for (int i = 0; i < 13; i++) step(4'b1000, 8'(i));
    clear_svc();
    chk("R9 svc cleared", svc_busy, 0);
    step(4'b0000, 8'h00);
    chk("R7 no irq at 13", irq, 0);
    step(4'b0001, 8'h00);
    chk("R7 level 12", level, 12);
    chk("R7 irq not yet", irq, 0);
    step(4'b0000, 8'h00);
    chk("R7 irq at 12", irq, 1);
    chk("R7 svc set", svc_busy, 1);
    step(4'b0000, 8'h00);
    chk("R9 masked after pulse", irq, 0);

    // R10 direction change flushes; request in change cycle ignored
    dir_rev = 1'b1;
    step(4'b0010, 8'hAB);
    chk("R10 level flushed", level, 0);
    chk("R10 empty after flush", empty, 1);

    // R8 reverse interrupt at threshold 12 (fires at 4)
    clear_svc();
    for (int i = 0; i < 3; i++) step(4'b0010, 8'(8'h50 + i));
    step(4'b0000, 8'h00);
    chk("R8 no irq at 3", irq, 0);
    step(4'b1000, 8'hCC);
    chk("R3 host write ignored in reverse", level, 3);
    step(4'b0010, 8'h53);
    step(4'b0000, 8'h00);
    chk("R8 irq at 4", irq, 1);
    for (int i = 0; i < 4; i++) begin
      step(4'b0100, 8'h00);
      chk("R2 reverse burst order", rd_data, 8'h50 + i);
    end
    step(4'b0001, 8'h00);
    chk("R3 per_pop ignored in reverse", rd_data, 8'h53);

    // R8 boundary: threshold 0 fires only when full
    thresh = 4'd0;
    clear_svc();
    for (int i = 0; i < 15; i++) step(4'b0010, 8'(8'h80 + i));
    step(4'b0000, 8'h00);
    chk("R8 thr0 no irq at 15", irq, 0);
    step(4'b0010, 8'h8F);
    step(4'b0000, 8'h00);
    chk("R8 thr0 irq at 16", irq, 1);
    chk("R11 full reverse", full, 1);
    for (int i = 0; i < 16; i++) begin
      step(4'b0100, 8'h00);
      chk("R2 full burst order", rd_data, 8'h80 + i);
    end
    step(4'b0100, 8'h00);
    chk("R5 empty read level", level, 0);
    chk("R5 empty read rd_data held", rd_data, 8'h8F);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule